// File: doc/BRIEF.md
# Lock Elision Buffer

This block sits between one hardware thread and shared memory and lets that thread run a lock-protected critical section without ever writing the lock word globally. When enabled, a store that carries an acquire hint is kept local. The block records the lock address, the value the thread stored and the value memory held before the store, then enters speculative mode. In that mode the thread's own loads of the lock address return the stored value. Memory, and so every other agent, keeps the unlocked value. Other stores are buffered and forwarded to later loads from the same thread. Addresses the thread loads are kept in a read set.

Snoop notifications from other agents are compared against the read set, the write buffer and the lock address. A conflict is remembered until the hinted release arrives. A clean release that restores the recorded old value commits: the buffered stores are written to memory one per cycle and the lock word is never touched. Otherwise the block aborts, discards the speculative state and pulses a restart. The thread's next acquire/release pair is then performed as ordinary visible writes.

Top module: `lock_elision_buffer`

## Requirements
- R1: After synchronous reset, `req_ready` is 1 and `spec_active`, `mem_wr_en`, `rsp_valid`, `abort_o` and `commit_o` are all 0.
- R2: With `elide_en`=1 and no elision running, a store with `req_hint`=2'b01 (acquire) does not write memory, and `spec_active` is 1 from the next cycle on. No memory write occurs while speculative.
- R3: While speculative, a thread load of the lock address returns the acquire store's data, while memory still holds the value seen before the acquire.
- R4: While speculative, an unhinted store (`req_hint`=2'b00) leaves memory unchanged. A later thread load of that address returns the most recent stored data.
- R5: A store with `req_hint`=2'b10 (release) to the lock address, carrying the recorded old value, with no conflict pending, gives a one-cycle `commit_o` in the next cycle. The buffered stores are then written to memory one per cycle in first-store order, with `req_ready` low until done. The lock word is never written.
- R6: A snoop write (`snp_write`=1) to an address in the read set, in the write buffer, or to the lock address makes the next hinted release abort. `abort_o` pulses, `spec_active` drops and no buffered store reaches memory.
- R7: A snoop read of an address in the write buffer is a conflict, with the same outcome as R6. A snoop read of an address that is only in the read set is not a conflict.
- R8: A hinted release whose address differs from the lock address, or whose data differs from the recorded old value, aborts.
- R9: A second hinted acquire while speculative aborts in the next cycle, and its store is not written to memory.
- R10: After an abort, the next hinted acquire and the hinted release after it are written to memory like plain stores, without speculation. The hinted acquire after that elides again.
- R11: With `elide_en`=0, hints are ignored: hinted and plain stores are written to memory in the cycle they are accepted, and `spec_active` stays 0.
- R12: While speculative, storing to more distinct addresses than `WBUF_DEPTH`, or loading more distinct non-lock addresses than `RSET_DEPTH`, makes the next hinted release abort.
- R13: An accepted load gives `rsp_valid` for one cycle in the next cycle, with the data. Outside speculation, or for an address neither buffered nor the lock, that data is the memory value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| elide_en | input | 1 | Allows hinted acquires to start speculation |
| req_valid | input | 1 | Thread request present |
| req_ready | output | 1 | Request accepted this cycle (low while committing) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_hint | input | 2 | 00 none, 01 acquire, 10 release (stores only) |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | DW | Load data |
| mem_rd_addr | output | AW | Shared memory read address (combinational read) |
| mem_rd_data | input | DW | Shared memory read data |
| mem_wr_en | output | 1 | Shared memory write strobe |
| mem_wr_addr | output | AW | Shared memory write address |
| mem_wr_data | output | DW | Shared memory write data |
| snp_valid | input | 1 | Access by another agent observed |
| snp_write | input | 1 | Observed access is a write |
| snp_addr | input | AW | Observed access address |
| spec_active | output | 1 | Elision in progress |
| commit_o | output | 1 | Elided section committed (pulse) |
| abort_o | output | 1 | Elided section aborted, restart required (pulse) |

## Verification
The bench builds the block with `RSET_DEPTH`=2 and `WBUF_DEPTH`=2, keeping `AW`=8 and `DW`=16. The small depths put both capacity aborts within three accesses. They also make a two-entry commit drain short enough to check entry by entry. With the 8-bit address, the bench can model the whole shared memory and check that lock words and buffered locations keep their global values through every speculative section, abort and commit.

// File: rtl/le_pkg.sv
// Shared types for the lock elision buffer.
// Assumes: hint codes are fixed by the thread interface.
package le_pkg;
    typedef enum logic [1:0] {
        HINT_NONE = 2'b00,
        HINT_ACQ  = 2'b01,
        HINT_REL  = 2'b10
    } hint_e;

    typedef enum logic [2:0] {
        ST_IDLE,   // no elision, plain accesses
        ST_SPEC,   // elided critical section in progress
        ST_RETRY,  // aborted, next acquire is performed visibly
        ST_HELD,   // visible lock held after a retry
        ST_DRAIN   // committing buffered stores to memory
    } state_e;
endpackage

// File: rtl/le_read_set.sv
// Read set: remembers distinct addresses loaded during speculation and
// flags a snooped address that matches one of them.
// Assumes: clear and ins_en are never high together with a useful insert.
module le_read_set #(
    parameter int AW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          ins_en,
    input  logic [AW-1:0] ins_addr,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_hit,
    output logic          ovf
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0]    addr_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] ins_match, snp_match;
    logic             present, full;
    logic [IW-1:0]    free_idx;

    // Per-entry comparators.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign ins_match[g] = vld_q[g] && (addr_q[g] == ins_addr);
        assign snp_match[g] = vld_q[g] && (addr_q[g] == snp_addr);
    end

    assign present = |ins_match;
    assign full    = &vld_q;
    assign snp_hit = |snp_match;
    assign ovf     = ins_en && !present && full;

    // Lowest free slot.
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) free_idx = IW'(i);
        end
    end

    // Valid bits: cleared on reset or new section, set on insert.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) vld_q <= '0;
        else if (ins_en && !present && !full) vld_q[free_idx] <= 1'b1;
    end

    // Address storage, written on insert.
    always_ff @(posedge clk) begin
        if (ins_en && !present && !full) addr_q[free_idx] <= ins_addr;
    end

    assert_grow_by_one_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vld_q) <= $countones($past(vld_q)) + 1);
endmodule

// File: rtl/le_write_buf.sv
// Write buffer: holds speculative stores in first-store order, merges
// repeated stores to one address, forwards data to loads, and drains one
// entry per cycle on commit.
// Assumes: wr_en and dr_pop are not used in the same cycle.
module le_write_buf #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_hit,
    output logic          ovf,
    input  logic          dr_pop,
    output logic          dr_valid,
    output logic [AW-1:0] dr_addr,
    output logic [DW-1:0] dr_data
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [CW-1:0]    cnt_q, dr_idx_q;
    logic [DEPTH-1:0] vld, wr_match, lk_match, snp_match;
    logic             wr_hit, full;
    logic [IW-1:0]    wr_idx, alloc_idx, dr_sel;

    // Per-entry occupancy and comparators.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign vld[g]       = CW'(g) < cnt_q;
        assign wr_match[g]  = vld[g] && (addr_q[g] == wr_addr);
        assign lk_match[g]  = vld[g] && (addr_q[g] == lk_addr);
        assign snp_match[g] = vld[g] && (addr_q[g] == snp_addr);
    end

    assign full      = (cnt_q == CW'(DEPTH));
    assign wr_hit    = |wr_match;
    assign lk_hit    = |lk_match;
    assign snp_hit   = |snp_match;
    assign ovf       = wr_en && !wr_hit && full;
    assign alloc_idx = cnt_q[IW-1:0];
    assign dr_sel    = dr_idx_q[IW-1:0];
    assign dr_valid  = dr_idx_q < cnt_q;
    assign dr_addr   = addr_q[dr_sel];
    assign dr_data   = data_q[dr_sel];

    // Match encoders for merge index and load forwarding.
    always_comb begin
        wr_idx  = '0;
        lk_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_match[i]) wr_idx = IW'(i);
            if (lk_match[i]) lk_data = data_q[i];
        end
    end

    // Fill and drain pointers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q    <= '0;
            dr_idx_q <= '0;
        end else begin
            if (wr_en && !wr_hit && !full) cnt_q <= cnt_q + CW'(1);
            if (dr_pop && dr_valid) dr_idx_q <= dr_idx_q + CW'(1);
        end
    end

    // Entry storage: merge on hit, allocate otherwise.
    always_ff @(posedge clk) begin
        if (wr_en && wr_hit) begin
            data_q[wr_idx] <= wr_data;
        end else if (wr_en && !full) begin
            addr_q[alloc_idx] <= wr_addr;
            data_q[alloc_idx] <= wr_data;
        end
    end

    assert_fill_bounded_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    assert_drain_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dr_idx_q <= cnt_q);
endmodule

// File: rtl/lock_elision_buffer.sv
// Lock elision buffer for one hardware thread.
// Keeps hinted lock stores local, buffers the critical section's stores,
// watches snooped accesses for conflicts and commits or aborts on the
// hinted release.
// Assumes: shared memory reads are combinational on mem_rd_addr; the
// memory side serialises the commit drain against other agents.
module lock_elision_buffer #(
    parameter int AW         = 8,
    parameter int DW         = 16,
    parameter int RSET_DEPTH = 4,
    parameter int WBUF_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          elide_en,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [1:0]    req_hint,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data,
    input  logic          snp_valid,
    input  logic          snp_write,
    input  logic [AW-1:0] snp_addr,
    output logic          spec_active,
    output logic          commit_o,
    output logic          abort_o
);
    import le_pkg::*;

    state_e        state_q;
    logic [AW-1:0] lock_addr_q;
    logic [DW-1:0] lock_new_q, lock_old_q, rsp_data_q;
    logic          doom_q, rsp_valid_q, commit_q, abort_q;

    hint_e         hint;
    logic          fire, ld, st_plain, is_acq, is_rel, spec, lock_hit;
    logic          start_spec, rel_ok, conflict_now, doom_set;
    logic          rs_ins, rs_snp_hit, rs_ovf;
    logic          wb_wr, wb_lk_hit, wb_snp_hit, wb_ovf, wb_dr_valid, wb_dr_pop;
    logic [DW-1:0] wb_lk_data, wb_dr_data;
    logic [AW-1:0] wb_dr_addr;

    // Request decode.
    assign hint       = hint_e'(req_hint);
    assign req_ready  = (state_q != ST_DRAIN);
    assign fire       = req_valid && req_ready;
    assign ld         = fire && !req_write;
    assign st_plain   = fire && req_write && (hint == HINT_NONE);
    assign is_acq     = fire && req_write && (hint == HINT_ACQ);
    assign is_rel     = fire && req_write && (hint == HINT_REL);
    assign spec       = (state_q == ST_SPEC);
    assign lock_hit   = (req_addr == lock_addr_q);
    assign start_spec = (state_q == ST_IDLE) && is_acq && elide_en;

    // Conflict and capacity detection while speculative.
    assign conflict_now = spec && snp_valid &&
        (snp_write ? (rs_snp_hit || wb_snp_hit || (snp_addr == lock_addr_q))
                   : wb_snp_hit);
    assign doom_set = conflict_now || rs_ovf || wb_ovf || (spec && st_plain && lock_hit);
    assign rel_ok   = !doom_q && !doom_set && lock_hit && (req_wdata == lock_old_q);

    assign rs_ins    = spec && ld && !lock_hit && !wb_lk_hit;
    assign wb_wr     = spec && st_plain && !lock_hit;
    assign wb_dr_pop = (state_q == ST_DRAIN);

    le_read_set #(.AW(AW), .DEPTH(RSET_DEPTH)) u_rset (
        .clk(clk), .rst_n(rst_n), .clear(start_spec),
        .ins_en(rs_ins), .ins_addr(req_addr),
        .snp_addr(snp_addr), .snp_hit(rs_snp_hit), .ovf(rs_ovf)
    );

    le_write_buf #(.AW(AW), .DW(DW), .DEPTH(WBUF_DEPTH)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .clear(start_spec),
        .wr_en(wb_wr), .wr_addr(req_addr), .wr_data(req_wdata),
        .lk_addr(req_addr), .lk_hit(wb_lk_hit), .lk_data(wb_lk_data),
        .snp_addr(snp_addr), .snp_hit(wb_snp_hit), .ovf(wb_ovf),
        .dr_pop(wb_dr_pop), .dr_valid(wb_dr_valid),
        .dr_addr(wb_dr_addr), .dr_data(wb_dr_data)
    );

    // Shared memory port: drain, suppressed, or pass-through stores.
    always_comb begin
        mem_wr_en   = 1'b0;
        mem_wr_addr = req_addr;
        mem_wr_data = req_wdata;
        if (state_q == ST_DRAIN) begin
            mem_wr_en   = wb_dr_valid;
            mem_wr_addr = wb_dr_addr;
            mem_wr_data = wb_dr_data;
        end else if (!spec) begin
            mem_wr_en = fire && req_write && !start_spec;
        end
    end
    assign mem_rd_addr = req_addr;

    // Section control state and pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            doom_q   <= 1'b0;
            commit_q <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            abort_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE:  if (start_spec) begin
                              state_q <= ST_SPEC;
                              doom_q  <= 1'b0;
                          end
                ST_SPEC:  if (is_acq || (is_rel && !rel_ok)) begin
                              state_q <= ST_RETRY;
                              abort_q <= 1'b1;
                          end else if (is_rel) begin
                              state_q  <= wb_dr_valid ? ST_DRAIN : ST_IDLE;
                              commit_q <= 1'b1;
                          end else if (doom_set) begin
                              doom_q <= 1'b1;
                          end
                ST_RETRY: if (is_acq) state_q <= ST_HELD;
                ST_HELD:  if (is_rel) state_q <= ST_IDLE;
                ST_DRAIN: if (!wb_dr_valid) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Lock word record captured at the eliding acquire.
    always_ff @(posedge clk) begin
        if (start_spec) begin
            lock_addr_q <= req_addr;
            lock_new_q  <= req_wdata;
            lock_old_q  <= mem_rd_data;
        end
    end

    // Load response with local view of lock word and buffered stores.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid_q <= 1'b0;
        else        rsp_valid_q <= ld;
        if (ld) begin
            if (spec && lock_hit)       rsp_data_q <= lock_new_q;
            else if (spec && wb_lk_hit) rsp_data_q <= wb_lk_data;
            else                        rsp_data_q <= mem_rd_data;
        end
    end

    assign rsp_valid   = rsp_valid_q;
    assign rsp_data    = rsp_data_q;
    assign spec_active = spec;
    assign commit_o    = commit_q;
    assign abort_o     = abort_q;

    assert_no_global_write_in_spec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spec_active |-> !mem_wr_en);
    assert_abort_enters_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (state_q == ST_RETRY));
    assert_commit_excl_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && abort_o));
    assert_drain_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> !req_ready);
    assert_disabled_no_spec_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!elide_en && state_q == ST_IDLE) |=> !spec_active);
    assert_second_acq_aborts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_active && is_acq) |=> abort_o);
endmodule

// File: tb/tb_lock_elision_buffer.sv
`timescale 1ns/1ps
module tb_lock_elision_buffer;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam time CLK_P = 8ns;

    logic clk = 0, rst_n = 0, elide_en = 0;
    logic req_valid = 0, req_write = 0, req_ready;
    logic [1:0] req_hint = 0;
    logic [AW-1:0] req_addr = 0, mem_rd_addr, mem_wr_addr, snp_addr = 0;
    logic [DW-1:0] req_wdata = 0, rsp_data, mem_rd_data, mem_wr_data;
    logic rsp_valid, mem_wr_en, snp_valid = 0, snp_write = 0;
    logic spec_active, commit_o, abort_o;

    logic [DW-1:0] mem [2**AW];
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    int n_cmp = 0, n_mis = 0, n_abort = 0, n_commit = 0;
    int e_abort = 0, e_commit = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    lock_elision_buffer #(.AW(AW), .DW(DW), .RSET_DEPTH(2), .WBUF_DEPTH(2)) dut (
        .clk(clk), .rst_n(rst_n), .elide_en(elide_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_hint(req_hint), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
        .spec_active(spec_active), .commit_o(commit_o), .abort_o(abort_o)
    );

    // Shared memory model.
    assign mem_rd_data = mem[mem_rd_addr];
    always @(posedge clk) if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;

    task automatic check(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_mis++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pulse counters and load-response scoreboard.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (abort_o)  n_abort++;
            if (commit_o) n_commit++;
            if (rsp_valid) begin
                if (exp_q.size() == 0) check(1, 0, "R13 unexpected response");
                else check(int'(rsp_data), int'(exp_q.pop_front()), tag_q.pop_front());
            end
        end
    end

    task automatic op(input logic wr, input logic [1:0] h, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
        req_valid = 1; req_write = wr; req_hint = h; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_hint = 0;
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        op(0, 2'b00, a, '0);
    endtask

    task automatic snoop(input logic [AW-1:0] a, input logic w);
        snp_valid = 1; snp_write = w; snp_addr = a;
        @(negedge clk);
        snp_valid = 0; snp_write = 0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 20 && !req_ready; i++) @(negedge clk);
    endtask

    task automatic check_pulses(input string tag);
        check(n_abort, e_abort, {tag, " abort count"});
        check(n_commit, e_commit, {tag, " commit count"});
    endtask

    // Visible acquire/release after an abort (R10).
    task automatic retry_pair();
        op(1, 2'b01, 8'h10, 16'h1);
        check(mem[8'h10], 1, "R10 retried acquire visible");
        check(spec_active, 0, "R10 no speculation on retry");
        op(1, 2'b10, 8'h10, 16'h0);
        check(mem[8'h10], 0, "R10 retried release visible");
    endtask

    initial begin
        for (int i = 0; i < 2**AW; i++) mem[i] = DW'(16'h1000 + i);
        mem[8'h10] = 0; mem[8'h11] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(req_ready, 1, "R1 ready"); check(spec_active, 0, "R1 spec");
        check(mem_wr_en, 0, "R1 wr"); check(rsp_valid, 0, "R1 rsp");
        check(abort_o | commit_o, 0, "R1 pulses");

        // Clean elided section with commit.
        elide_en = 1;
        op(1, 2'b01, 8'h10, 16'h1);
        check(spec_active, 1, "R2 spec after acquire");
        check(mem[8'h10], 0, "R2 lock not written");
        load(8'h10, 16'h1, "R3 local lock view");
        check(mem[8'h10], 0, "R3 global lock view");
        load(8'h20, 16'h1020, "R13 memory load");
        op(1, 2'b00, 8'h30, 16'hAAAA);
        check(mem[8'h30], 16'h1030, "R4 store buffered");
        load(8'h30, 16'hAAAA, "R4 forward");
        op(1, 2'b00, 8'h30, 16'hBBBB);
        op(1, 2'b00, 8'h31, 16'hCCCC);
        load(8'h30, 16'hBBBB, "R4 merged forward");
        snoop(8'h20, 0);
        op(1, 2'b10, 8'h10, 16'h0);
        e_commit++;
        check_pulses("R5/R7 read-set read no conflict");
        check(req_ready, 0, "R5 stall during drain");
        wait_ready();
        check(mem[8'h30], 16'hBBBB, "R5 drained 0x30");
        check(mem[8'h31], 16'hCCCC, "R5 drained 0x31");
        check(mem[8'h10], 0, "R5 lock never written");
        check(spec_active, 0, "R5 spec cleared");

        // Snoop write to a read-set address.
        op(1, 2'b01, 8'h10, 16'h1);
        load(8'h20, 16'h1020, "R13 load in section");
        op(1, 2'b00, 8'h40, 16'h5555);
        snoop(8'h20, 1);
        check_pulses("R6 conflict held to release");
        op(1, 2'b10, 8'h10, 16'h0);
        e_abort++;
        check_pulses("R6 read-set write conflict");
        check(spec_active, 0, "R6 spec dropped");
        repeat (3) @(negedge clk);
        check(mem[8'h40], 16'h1040, "R6 buffered store discarded");
        retry_pair();
        op(1, 2'b01, 8'h10, 16'h1);
        check(spec_active, 1, "R10 elides again after retry");
        op(1, 2'b10, 8'h10, 16'h0);
        e_commit++;
        check_pulses("R10 empty commit");

        // Snoop write to the lock word.
        op(1, 2'b01, 8'h10, 16'h1);
        snoop(8'h10, 1);
        op(1, 2'b10, 8'h10, 16'h0);
        e_abort++;
        check_pulses("R6 lock-word write conflict");
        retry_pair();

        // Snoop read of a buffered address.
        op(1, 2'b01, 8'h10, 16'h1);
        op(1, 2'b00, 8'h50, 16'h0001);
        snoop(8'h50, 0);
        op(1, 2'b10, 8'h10, 16'h0);
        e_abort++;
        check_pulses("R7 write-set read conflict");
        check(mem[8'h50], 16'h1050, "R7 no drain");
        retry_pair();

        // Release value mismatch.
        op(1, 2'b01, 8'h10, 16'h1);
        op(1, 2'b10, 8'h10, 16'h2);
        e_abort++;
        check_pulses("R8 value mismatch");
        check(mem[8'h10], 0, "R8 lock untouched");
        retry_pair();
        // Release address mismatch.
        op(1, 2'b01, 8'h10, 16'h1);
        op(1, 2'b10, 8'h11, 16'h0);
        e_abort++;
        check_pulses("R8 address mismatch");
        retry_pair();

        // Second acquire while speculative.
        op(1, 2'b01, 8'h10, 16'h1);
        op(1, 2'b01, 8'h11, 16'h1);
        e_abort++;
        check_pulses("R9 second acquire");
        check(mem[8'h11], 0, "R9 second lock not written");
        check(spec_active, 0, "R9 spec dropped");
        retry_pair();

        // Write buffer capacity.
        op(1, 2'b01, 8'h10, 16'h1);
        op(1, 2'b00, 8'h60, 16'h6);
        op(1, 2'b00, 8'h61, 16'h6);
        op(1, 2'b00, 8'h62, 16'h6);
        op(1, 2'b10, 8'h10, 16'h0);
        e_abort++;
        check_pulses("R12 write buffer overflow");
        check(mem[8'h60], 16'h1060, "R12 stores discarded");
        retry_pair();
        // Read set capacity.
        op(1, 2'b01, 8'h10, 16'h1);
        load(8'h70, 16'h1070, "R13 load 0x70");
        load(8'h71, 16'h1071, "R13 load 0x71");
        load(8'h72, 16'h1072, "R13 load 0x72");
        op(1, 2'b10, 8'h10, 16'h0);
        e_abort++;
        check_pulses("R12 read set overflow");
        retry_pair();

        // Elision disabled.
        elide_en = 0;
        op(1, 2'b01, 8'h10, 16'h1);
        check(mem[8'h10], 1, "R11 hinted acquire visible");
        check(spec_active, 0, "R11 no speculation");
        op(1, 2'b00, 8'h80, 16'h8888);
        check(mem[8'h80], 16'h8888, "R11 plain store visible");
        load(8'h80, 16'h8888, "R13 load after plain store");
        op(1, 2'b10, 8'h10, 16'h0);
        check(mem[8'h10], 0, "R11 hinted release visible");
        @(negedge clk);
        check_pulses("R11 no pulses");
        check(exp_q.size(), 0, "R13 all responses seen");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    // Watchdog.
    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_cmp++; n_mis++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end
endmodule